// File: doc/BRIEF.md
# Transfer Descriptor Status Write-Back Unit

This block sits between the transaction engine of a USB host controller and the memory port that stores transfer descriptors. When a transaction ends, the engine presents the fetched control/status word of the descriptor, a result code, the actual and maximum byte counts and the direction and queue flags. One cycle later the block returns the updated word with a write-back strobe. The updated word has a new retry budget, a new active bit and new status flags. With the same strobe it also says whether the queue may advance to the next element.

Completion and error interrupts are not raised at the moment they are caused. Each cause is held in a pending flag until the next end-of-frame strobe. At that point the block pulses the matching interrupt output for one cycle and clears the flag. A descriptor found inactive at fetch can still request a completion interrupt through a separate skip strobe.

Top module: `usb_td_status_wb`

## Requirements
- R1: While reset is held and in the first cycle after it, `wb_valid_o`, `queue_adv_o`, `cmp_irq_o` and `err_irq_o` are 0.
- R2: One cycle after `xfer_done_i`, `wb_valid_o` pulses and `wb_word_o` is driven. In that word, bits 31:29, 26:24 and 15:0 equal those of `td_word_i`. Bit 29 is short-packet enable, 26 low speed, 25 isochronous and 24 interrupt-on-complete.
- R3: Result code 0 (success) clears active bit 23 and clears status bits 22:17.
- R4: Result codes 1 (CRC), 2 (timeout), 3 (data buffer) and 4 (bit stuff) decrement the 2-bit retry counter in bits 28:27 when it is nonzero. A counter of zero stays zero and the active bit is kept.
- R5: When one of those codes takes the counter from 1 to 0, the word is written back with active=0 and stalled bit 22=1. It also sets the cause bit: bit 18 for CRC or timeout, bit 21 for data buffer, bit 17 for bit stuff.
- R6: Code 5 (NAK) leaves the counter and the active bit unchanged and sets NAK bit 19.
- R7: Code 6 (stall) and code 7 (babble) clear active and set stalled bit 22 for any counter value, without changing the counter. Babble also sets bit 20.
- R8: When isochronous bit 25 is set, the written-back active bit is 0 for every result code.
- R9: A short packet is a successful input transaction (`dir_in_i`=1) in a queue (`in_queue_i`=1), with bit 29 set and `act_len_i` < `max_len_i`. It clears active, holds `queue_adv_o` at 0, and latches a completion interrupt if `irq_mask_i[0]` is 1. Any error code prevents a short-packet report.
- R10: A counter reaching zero through a data buffer or bit-stuff error always latches an error interrupt. Through a CRC or timeout error it latches one only when `irq_mask_i[1]` is 1.
- R11: A completion interrupt is latched whenever `xfer_done_i` or `td_skip_i` arrives with bit 24 of `td_word_i` set, whatever the result.
- R12: Latched causes give no output until `eof_i`. One cycle after `eof_i`, each pending cause pulses its output for exactly one cycle and the pending flag clears. A cause arriving in the same cycle as `eof_i` is held for the next frame.
- R13: `queue_adv_o` is 1 with `wb_valid_o` exactly when the result is success and no short packet is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| td_word_i | input | 32 | Fetched descriptor control/status word |
| xfer_done_i | input | 1 | Transaction finished, result valid |
| td_skip_i | input | 1 | Descriptor fetched inactive, no transaction |
| result_i | input | 3 | Result code 0..7 (see R3-R7) |
| act_len_i | input | LEN_W | Actual byte count |
| max_len_i | input | LEN_W | Maximum byte count |
| dir_in_i | input | 1 | 1 = input (device to host) transaction |
| in_queue_i | input | 1 | Descriptor belongs to a queue |
| eof_i | input | 1 | End-of-frame strobe |
| irq_mask_i | input | 2 | [0] short-packet interrupt, [1] CRC/timeout exhaustion interrupt |
| wb_valid_o | output | 1 | Write-back strobe |
| wb_word_o | output | 32 | Updated descriptor word |
| queue_adv_o | output | 1 | Queue may advance |
| cmp_irq_o | output | 1 | Completion interrupt pulse |
| err_irq_o | output | 1 | Error interrupt pulse |

## Verification
The bench works the retry counter at its edges. It checks that a counter of one exhausts with the correct cause bit and stalled flag. It checks that a zero counter is never decremented: a design that wraps it to three would hand a broken endpoint three more retries. It checks that NAK, stall and babble leave the budget alone. It sends a short packet against equal lengths, against an error code and against a cleared enable. A design that compares lengths loosely, or reports short packets on failed transfers, would stop a queue that should advance. Interrupt timing is probed with causes held across idle cycles, with a cause that lands in the same cycle as the frame-end strobe, and with an isochronous descriptor that fails but must still be retired.

// File: rtl/usb_td_status_wb.sv
module usb_td_status_wb #(
  parameter int LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      td_word_i,
  input  logic             xfer_done_i,
  input  logic             td_skip_i,
  input  logic [2:0]       result_i,
  input  logic [LEN_W-1:0] act_len_i,
  input  logic [LEN_W-1:0] max_len_i,
  input  logic             dir_in_i,
  input  logic             in_queue_i,
  input  logic             eof_i,
  input  logic [1:0]       irq_mask_i,
  output logic             wb_valid_o,
  output logic [31:0]      wb_word_o,
  output logic             queue_adv_o,
  output logic             cmp_irq_o,
  output logic             err_irq_o
);

  localparam logic [2:0] RES_OK   = 3'd0;
  localparam logic [2:0] RES_CRC  = 3'd1;
  localparam logic [2:0] RES_TMO  = 3'd2;
  localparam logic [2:0] RES_DBUF = 3'd3;
  localparam logic [2:0] RES_STUF = 3'd4;
  localparam logic [2:0] RES_NAK  = 3'd5;
  localparam logic [2:0] RES_STL  = 3'd6;
  localparam logic [2:0] RES_BAB  = 3'd7;

  localparam int B_SPD = 29, B_ISO = 25, B_IOC = 24, B_ACT = 23;

  logic [1:0] cnt_in, cnt_nx;
  logic is_ok, counted, exhausted, halt_res, crc_like, retire, short_pkt;
  logic [5:0] stat_nx;
  logic [31:0] word_nx;
  logic cmp_set, err_set, cmp_pend, err_pend;

  assign cnt_in    = td_word_i[28:27];
  assign is_ok     = (result_i == RES_OK);
  assign crc_like  = (result_i == RES_CRC) || (result_i == RES_TMO);
  assign counted   = crc_like || (result_i == RES_DBUF) || (result_i == RES_STUF);
  assign exhausted = counted && (cnt_in == 2'd1);
  assign halt_res  = (result_i == RES_STL) || (result_i == RES_BAB);
  assign cnt_nx    = (counted && cnt_in != 2'd0) ? cnt_in - 2'd1 : cnt_in;

  assign short_pkt = is_ok && td_word_i[B_SPD] && dir_in_i && in_queue_i
                     && (act_len_i < max_len_i);

  assign retire = is_ok || exhausted || halt_res || td_word_i[B_ISO];

  assign stat_nx = {exhausted || halt_res,
                    exhausted && (result_i == RES_DBUF),
                    result_i == RES_BAB,
                    result_i == RES_NAK,
                    exhausted && crc_like,
                    exhausted && (result_i == RES_STUF)};

  always_comb begin
    word_nx        = td_word_i;
    word_nx[28:27] = cnt_nx;
    word_nx[B_ACT] = td_word_i[B_ACT] && !retire;
    word_nx[22:17] = stat_nx;
  end

  assign cmp_set = ((xfer_done_i || td_skip_i) && td_word_i[B_IOC])
                   || (xfer_done_i && short_pkt && irq_mask_i[0]);
  assign err_set = xfer_done_i && exhausted
                   && (!crc_like || irq_mask_i[1]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid_o  <= 1'b0;
      wb_word_o   <= '0;
      queue_adv_o <= 1'b0;
    end else begin
      wb_valid_o  <= xfer_done_i;
      queue_adv_o <= xfer_done_i && is_ok && !short_pkt;
      if (xfer_done_i) wb_word_o <= word_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_pend  <= 1'b0;
      err_pend  <= 1'b0;
      cmp_irq_o <= 1'b0;
      err_irq_o <= 1'b0;
    end else begin
      cmp_irq_o <= eof_i && cmp_pend;
      err_irq_o <= eof_i && err_pend;
      cmp_pend  <= (cmp_pend && !eof_i) || cmp_set;
      err_pend  <= (err_pend && !eof_i) || err_set;
    end
  end

  // R2
  wb_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_i |=> wb_valid_o);

  // R2
  keep_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_i |=> ({wb_word_o[31:29], wb_word_o[26:24], wb_word_o[15:0]} ==
                     {$past(td_word_i[31:29]), $past(td_word_i[26:24]), $past(td_word_i[15:0])}));

  // R4
  cnt_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_i |=> (wb_word_o[28:27] <= $past(td_word_i[28:27])));

  // R8
  iso_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid_o && wb_word_o[B_ISO]) |-> !wb_word_o[B_ACT]);

  // R13
  qadv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    queue_adv_o |-> (wb_valid_o && !wb_word_o[B_ACT]));

  // R12
  irq_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_irq_o || err_irq_o) |-> $past(eof_i));

  // R12
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq_o |=> !cmp_irq_o);

endmodule

// File: tb/tb_usb_td_status_wb.sv
`timescale 1ns/1ps
module tb_usb_td_status_wb;
  localparam int LW = 11;

  logic clk = 0, rst_n = 0;
  logic [31:0] td_word_i = '0;
  logic xfer_done_i = 0, td_skip_i = 0, dir_in_i = 0, in_queue_i = 0, eof_i = 0;
  logic [2:0] result_i = '0;
  logic [LW-1:0] act_len_i = '0, max_len_i = '0;
  logic [1:0] irq_mask_i = '0;
  logic wb_valid_o, queue_adv_o, cmp_irq_o, err_irq_o;
  logic [31:0] wb_word_o;

  usb_td_status_wb #(.LEN_W(LW)) dut (.*);

  always #10 clk = ~clk;

  typedef struct packed { logic [31:0] w; logic q; logic [7:0] tag; } exp_t;
  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  logic exp_cmp = 0, exp_err = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [1:0] c, input logic act,
                                     input logic iso, input logic ioc, input logic spd);
    mk = 32'h4000_0000 | 32'h0000_5A3C;
    mk[29] = spd; mk[28:27] = c; mk[25] = iso; mk[24] = ioc; mk[23] = act;
    mk[22:17] = 6'b101010;
  endfunction

  task automatic xfer(input string req, input logic [31:0] w, input logic [2:0] r,
                      input int al, input int ml, input logic din, input logic inq);
    exp_t e;
    logic [1:0] c;
    logic fin, shortp, errc;
    c = w[28:27];
    e.w = w; e.w[22:17] = '0; e.q = 0;
    e.tag = {req.getc(1), req.getc(req.len() > 2 ? 2 : 1)};
    errc = (r >= 3'd1 && r <= 3'd4);
    fin = errc && c == 2'd1;
    shortp = (r == 3'd0) && w[29] && din && inq && (al < ml);
    case (r)
      3'd0: begin e.w[23] = 0; e.q = !shortp; end
      3'd5: e.w[19] = 1;
      3'd6: begin e.w[23] = 0; e.w[22] = 1; end
      3'd7: begin e.w[23] = 0; e.w[22] = 1; e.w[20] = 1; end
      default: begin
        if (c != 0) e.w[28:27] = c - 1;
        if (fin) begin
          e.w[23] = 0; e.w[22] = 1;
          if (r == 3'd3) e.w[21] = 1;
          else if (r == 3'd4) e.w[17] = 1;
          else e.w[18] = 1;
        end
      end
    endcase
    if (w[25]) e.w[23] = 0;
    if (w[24] || (shortp && irq_mask_i[0])) exp_cmp = 1;
    if (fin && (r == 3'd3 || r == 3'd4 || irq_mask_i[1])) exp_err = 1;
    sb.push_back(e);
    @(negedge clk);
    td_word_i = w; result_i = r; act_len_i = LW'(al); max_len_i = LW'(ml);
    dir_in_i = din; in_queue_i = inq; xfer_done_i = 1;
    @(negedge clk);
    xfer_done_i = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && wb_valid_o) begin
      if (sb.size() == 0) chk("R2 unexpected write-back", 32'd1, 32'd0);
      else begin
        exp_t e;
        e = sb.pop_front();
        chk($sformatf("R2-R9 word (case %s)", string'(e.tag)), wb_word_o, e.w);
        chk($sformatf("R13 queue advance (case %s)", string'(e.tag)), {31'd0, queue_adv_o}, {31'd0, e.q});
      end
    end
  end

  task automatic frame_end(input string req);
    @(negedge clk); eof_i = 1;
    @(negedge clk); eof_i = 0;
    chk({req, " R12 completion pulse"}, {31'd0, cmp_irq_o}, {31'd0, exp_cmp});
    chk({req, " R12 error pulse"}, {31'd0, err_irq_o}, {31'd0, exp_err});
    exp_cmp = 0; exp_err = 0;
    @(negedge clk);
    chk("R12 pulse is one cycle", {30'd0, cmp_irq_o, err_irq_o}, 32'd0);
  endtask

  task automatic report;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {28'd0, wb_valid_o, queue_adv_o, cmp_irq_o, err_irq_o}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset", {28'd0, wb_valid_o, queue_adv_o, cmp_irq_o, err_irq_o}, 32'd0);

    xfer("R3 ok", mk(2'd3, 1, 0, 0, 0), 3'd0, 8, 8, 0, 0);
    xfer("R4 crc 3", mk(2'd3, 1, 0, 0, 0), 3'd1, 0, 8, 1, 0);
    xfer("R4 stuff 2", mk(2'd2, 1, 0, 0, 0), 3'd4, 0, 8, 1, 0);
    xfer("R4 zero cnt", mk(2'd0, 1, 0, 0, 0), 3'd2, 0, 8, 1, 0);
    xfer("R6 nak", mk(2'd1, 1, 0, 0, 0), 3'd5, 0, 8, 1, 0);
    xfer("R7 stall", mk(2'd3, 1, 0, 0, 0), 3'd6, 0, 8, 1, 0);
    xfer("R7 babble", mk(2'd0, 1, 0, 0, 0), 3'd7, 0, 8, 1, 0);
    frame_end("R10 no cause");

    irq_mask_i = 2'b00;
    xfer("R5 crc exhaust", mk(2'd1, 1, 0, 0, 0), 3'd1, 0, 8, 1, 0);
    frame_end("R10 crc masked");
    irq_mask_i = 2'b10;
    xfer("R5 tmo exhaust", mk(2'd1, 1, 0, 0, 0), 3'd2, 0, 8, 1, 0);
    frame_end("R10 tmo enabled");
    irq_mask_i = 2'b00;
    xfer("R5 dbuf exhaust", mk(2'd1, 1, 0, 0, 0), 3'd3, 0, 8, 0, 0);
    repeat (4) @(negedge clk);
    chk("R12 held before eof", {30'd0, cmp_irq_o, err_irq_o}, 32'd0);
    frame_end("R10 dbuf");
    xfer("R5 stuff exhaust", mk(2'd1, 1, 0, 1, 0), 3'd4, 0, 8, 0, 0);
    frame_end("R10 R11 stuff+ioc");

    xfer("R8 iso crc", mk(2'd3, 1, 1, 0, 0), 3'd1, 0, 8, 1, 0);
    xfer("R8 iso nak", mk(2'd0, 1, 1, 0, 0), 3'd5, 0, 8, 1, 0);

    irq_mask_i = 2'b01;
    xfer("R9 short", mk(2'd2, 1, 0, 0, 1), 3'd0, 5, 8, 1, 1);
    frame_end("R9 short irq");
    xfer("R9 equal len", mk(2'd2, 1, 0, 0, 1), 3'd0, 8, 8, 1, 1);
    xfer("R9 out dir", mk(2'd2, 1, 0, 0, 1), 3'd0, 5, 8, 0, 1);
    xfer("R9 with error", mk(2'd2, 1, 0, 0, 1), 3'd1, 5, 8, 1, 1);
    frame_end("R9 no short irq");
    irq_mask_i = 2'b00;
    xfer("R9 short masked", mk(2'd2, 1, 0, 0, 1), 3'd0, 5, 8, 1, 1);
    frame_end("R9 masked");

    @(negedge clk); td_word_i = mk(2'd0, 0, 0, 1, 0); td_skip_i = 1;
    exp_cmp = 1;
    @(negedge clk); td_skip_i = 0;
    frame_end("R11 skip ioc");

    @(negedge clk);
    td_word_i = mk(2'd3, 1, 0, 1, 0); result_i = 3'd0; xfer_done_i = 1; eof_i = 1;
    sb.push_back('{w: (mk(2'd3, 1, 0, 1, 0) & ~32'h00FE_0000), q: 1'b1, tag: "EF"});
    @(negedge clk); xfer_done_i = 0; eof_i = 0;
    chk("R12 same-cycle cause not in this frame", {31'd0, cmp_irq_o}, 32'd0);
    exp_cmp = 1;
    frame_end("R12 R11 deferred");

    repeat (3) @(negedge clk);
    chk("R2 scoreboard drained", sb.size(), 32'd0);
    report();
  end
endmodule